// File: doc/BRIEF.md
# ROM-Streaming Ripple Address Counter

This block is a binary up-counter with a configurable number of stages whose value also addresses a small byte-wide lookup memory. Each time the count moves, the block publishes the new count together with the byte stored at that address and raises a one-cycle strobe. A downstream consumer that has no memory port of its own, such as a sample-playback engine, can therefore be fed a stream of bytes by toggling a slow external clock line.

The external clock line is asynchronous. It passes through a synchroniser, and only its high-to-low transitions advance the count. A free-run input makes the count advance on every system clock cycle instead. An active-high clear input forces the count to zero and freezes it for as long as it is held. A parameter removes the memory, and the block then reduces to a counter with a strobe.

Top module: `rom_addr_streamer`

## Requirements
- R1: While `rst_ni` is low, and on the first cycles after it rises, `count_o` is 0, `data_o` is 0 and `strobe_o` is 0.
- R2: Each high-to-low transition of `ext_clk_i` that is held for at least one system clock cycle on either side advances the count by exactly one. With the default two synchroniser stages, a level change seen at system clock edge p reaches `count_o` after edge p+3.
- R3: A low-to-high transition of `ext_clk_i`, or a level held steady, leaves the count unchanged.
- R4: One cycle with `clear_i` high and a non-zero count sets the count to 0, and publishes count 0 with its byte and a strobe. When the count is already 0, `clear_i` produces no strobe.
- R5: While `clear_i` is high, neither falling edges of `ext_clk_i` nor `free_run_i` advance the count. Falling edges that arrive during clear are not counted after clear is released.
- R6: The count wraps from 2^STAGES-1 to 0.
- R7: When `ROM_EN`=1, `data_o` always equals the byte stored at address `count_o`. Entry a holds (a*ROM_MUL + ROM_ADD) mod 256.
- R8: `strobe_o` is high for one cycle for each change of the count, in the cycle in which the new `count_o`/`data_o` pair first appears. Without a strobe, both outputs hold their values.
- R9: With `free_run_i` high and `clear_i` low, the count advances by exactly one per system clock cycle. A simultaneous falling edge does not add a second step.
- R10: When `ROM_EN`=0, `data_o` stays 0, and the count and strobe behave as with the memory present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | Asynchronous counting clock; counts on its falling edge |
| clear_i | input | 1 | Synchronous active-high clear and hold |
| free_run_i | input | 1 | Advance on every system clock cycle |
| count_o | output | STAGES | Published count, which is also the memory address |
| data_o | output | 8 | Byte stored at `count_o` |
| strobe_o | output | 1 | One-cycle pulse marking a new count/data pair |

## Verification
A wrong count inside the block appears at `count_o` one cycle after it arises, and `data_o` then carries the wrong byte in the same cycle. A missed or doubled edge shows up as an off-by-one count four cycles after the stimulus, and this error persists across all later updates. The per-cycle reference model catches a strobe that is missing or extra in the very cycle it occurs, and catches a clear that fails to hold in the first cycle the count moves. Wrap behaviour is checked on both a wide and a three-stage instance.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned BYTE_W = 8;

  // Memory image generator: entry a = (a*mul + add) mod 256
  function automatic logic [BYTE_W-1:0] rom_byte(input int unsigned a,
                                                 input int unsigned mul,
                                                 input int unsigned add);
    int unsigned t;
    t = a * mul + add;
    return t[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/rsc_fall_detect.sv
module rsc_fall_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  localparam int unsigned LEN = SYNC_STAGES + 1;

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LEN-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  // last synchronised level low, previous one high
  assign fall_o = sh_q[LEN-1] & ~sh_q[LEN-2];
endmodule

// File: rtl/rsc_count_core.sv
module rsc_count_core #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o,
  output logic          upd_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_q, upd_d;

  always_comb begin
    cnt_d = cnt_q;
    upd_d = 1'b0;
    if (clear_i) begin
      if (cnt_q != '0) begin
        cnt_d = '0;
        upd_d = 1'b1;
      end
    end else if (step_i) begin
      cnt_d = cnt_q + CW'(1);
      upd_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      upd_q <= upd_d;
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/rsc_byte_rom.sv
module rsc_byte_rom #(
  parameter int unsigned AW      = 8,
  parameter bit          ROM_EN  = 1'b1,
  parameter int unsigned ROM_MUL = 37,
  parameter int unsigned ROM_ADD = 11
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [AW-1:0]             addr_i,
  output logic [AW-1:0]             addr_o,
  output logic [rsc_pkg::BYTE_W-1:0] data_o,
  output logic                      vld_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned DW    = rsc_pkg::BYTE_W;

  logic [DW-1:0] rd_w;

  if (ROM_EN) begin : g_rom
    logic [DW-1:0] tbl [DEPTH];
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      assign tbl[g] = rsc_pkg::rom_byte(g, ROM_MUL, ROM_ADD);
    end
    assign rd_w = tbl[addr_i];
  end else begin : g_norom
    assign rd_w = '0;
  end

  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          vld_q;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (load_i) begin
      addr_d = addr_i;
      data_d = rd_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      vld_q  <= load_i;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/rom_addr_streamer.sv
module rom_addr_streamer #(
  parameter int unsigned STAGES      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ROM_EN      = 1'b1,
  parameter int unsigned ROM_MUL     = 37,
  parameter int unsigned ROM_ADD     = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              clear_i,
  input  logic              free_run_i,
  output logic [STAGES-1:0] count_o,
  output logic [7:0]        data_o,
  output logic              strobe_o
);
  logic              fall_w;
  logic              step_w;
  logic [STAGES-1:0] cnt_q;
  logic              upd_w;

  rsc_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_clk_i),
    .fall_o (fall_w)
  );

  assign step_w = fall_w | free_run_i;

  rsc_count_core #(.CW(STAGES)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .step_i (step_w),
    .cnt_o  (cnt_q),
    .upd_o  (upd_w)
  );

  rsc_byte_rom #(
    .AW(STAGES), .ROM_EN(ROM_EN), .ROM_MUL(ROM_MUL), .ROM_ADD(ROM_ADD)
  ) u_rom (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(upd_w),
    .addr_i(cnt_q),
    .addr_o(count_o),
    .data_o(data_o),
    .vld_o (strobe_o)
  );
endmodule

// File: rtl/rom_addr_streamer_chk.sv
module rom_addr_streamer_chk #(
  parameter int unsigned STAGES  = 8,
  parameter bit          ROM_EN  = 1'b1,
  parameter int unsigned ROM_MUL = 37,
  parameter int unsigned ROM_ADD = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              free_run_i,
  input logic [STAGES-1:0] cnt_q,
  input logic [STAGES-1:0] count_o,
  input logic [7:0]        data_o,
  input logic              strobe_o
);
  // R4
  p_clear_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));

  // R9
  p_run_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_run_i && !clear_i) |=> (cnt_q == STAGES'($past(cnt_q) + 1'b1)));

  // R8
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> ($stable(count_o) && $stable(data_o)));

  // R2
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && count_o != '0) |-> (count_o == STAGES'($past(count_o) + 1'b1)));

  if (ROM_EN) begin : g_data
    // R7
    p_data_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_o |-> (data_o == rsc_pkg::rom_byte(32'(count_o), ROM_MUL, ROM_ADD)));
  end else begin : g_nodata
    // R10
    p_data_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      data_o == 8'h00);
  end
endmodule

bind rom_addr_streamer rom_addr_streamer_chk #(
  .STAGES(STAGES), .ROM_EN(ROM_EN), .ROM_MUL(ROM_MUL), .ROM_ADD(ROM_ADD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .free_run_i(free_run_i),
  .cnt_q     (cnt_q),
  .count_o   (count_o),
  .data_o    (data_o),
  .strobe_o  (strobe_o)
);

// File: tb/sim_rom_addr_streamer.sv
module sim_rom_addr_streamer;
  localparam int W0 = 8, W1 = 3, MUL = 37, ADD = 11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ext_clk, clear, run;
  logic [W0-1:0] cnt0; logic [7:0] dat0; logic stb0;
  logic [W1-1:0] cnt1; logic [7:0] dat1; logic stb1;

  rom_addr_streamer #(.STAGES(W0), .ROM_EN(1'b1), .ROM_MUL(MUL), .ROM_ADD(ADD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .clear_i(clear),
    .free_run_i(run), .count_o(cnt0), .data_o(dat0), .strobe_o(stb0));

  rom_addr_streamer #(.STAGES(W1), .ROM_EN(1'b0), .ROM_MUL(MUL), .ROM_ADD(ADD)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .clear_i(clear),
    .free_run_i(run), .count_o(cnt1), .data_o(dat1), .strobe_o(stb1));

  int checks = 0, fails = 0;
  string req_tag = "R1";
  bit done = 1'b0;

  function automatic int rom_val(int a);
    return (a * MUL + ADD) % 256;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: sampled levels of ext_clk, count, pending publish
  int h1, h2, h3;
  int mc[2], mu[2], oc[2], od[2], os[2];
  int mask[2] = '{255, 7};
  int ren[2]  = '{1, 0};
  bit fall;

  always @(negedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0;
      for (int i = 0; i < 2; i++) begin
        mc[i] = 0; mu[i] = 0; oc[i] = 0; od[i] = 0; os[i] = 0;
      end
    end else begin
      fall = (h3 == 1) && (h2 == 0);
      h3 = h2; h2 = h1; h1 = int'(ext_clk);
      for (int i = 0; i < 2; i++) begin
        os[i] = mu[i];
        if (mu[i] != 0) begin
          oc[i] = mc[i];
          od[i] = (ren[i] != 0) ? rom_val(mc[i]) : 0;
        end
        if (clear) begin
          mu[i] = (mc[i] != 0) ? 1 : 0;
          mc[i] = 0;
        end else if (fall || run) begin
          mc[i] = (mc[i] + 1) & mask[i];
          mu[i] = 1;
        end else begin
          mu[i] = 0;
        end
      end
    end
    if (!done) begin
      check(req_tag, "u0.count", int'(cnt0), oc[0]);
      check("R7",    "u0.data",  int'(dat0), od[0]);
      check("R8",    "u0.strobe", int'(stb0), os[0]);
      check(req_tag, "u1.count", int'(cnt1), oc[1]);
      check("R10",   "u1.data",  int'(dat1), od[1]);
      check("R8",    "u1.strobe", int'(stb1), os[1]);
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic pulse(int hi, int lo);
    ext_clk = 1'b1; step(hi);
    ext_clk = 1'b0; step(lo);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    rst_n = 1'b0; ext_clk = 1'b0; clear = 1'b0; run = 1'b0;
    step(3);
    check("R1", "reset count", int'(cnt0), 0);
    check("R1", "reset data",  int'(dat0), 0);
    check("R1", "reset strobe", int'(stb0), 0);
    rst_n = 1'b1;
    step(3);
    check("R1", "post-reset count", int'(cnt0), 0);

    req_tag = "R2";
    repeat (10) pulse(3, 3);
    step(6);
    check("R2", "u0 count after 10 falls", int'(cnt0), 10);
    check("R2", "u1 count after 10 falls", int'(cnt1), 2);

    req_tag = "R3";
    ext_clk = 1'b1;
    step(12);
    check("R3", "count after rise and steady high", int'(cnt0), 10);
    ext_clk = 1'b0;
    step(6);
    check("R3", "count after following fall", int'(cnt0), 11);

    req_tag = "R9";
    run = 1'b1;
    step(250);
    run = 1'b0;
    step(4);
    check("R6", "u0 wrapped count", int'(cnt0), 5);
    check("R9", "u1 free-run count", int'(cnt1), 5);
    check("R7", "u0 data at 5", int'(dat0), rom_val(5));

    req_tag = "R4";
    clear = 1'b1; step(1); clear = 1'b0;
    step(4);
    check("R4", "count after clear", int'(cnt0), 0);
    check("R4", "data after clear", int'(dat0), rom_val(0));
    clear = 1'b1; step(1); clear = 1'b0;
    step(4);
    check("R4", "no strobe for clear at zero", int'(stb0), 0);

    req_tag = "R5";
    clear = 1'b1;
    repeat (3) pulse(2, 2);
    run = 1'b1; step(8); run = 1'b0;
    step(2);
    check("R5", "count held during clear", int'(cnt0), 0);
    clear = 1'b0;
    step(6);
    check("R5", "no late count after release", int'(cnt0), 0);

    req_tag = "R2";
    repeat (20) pulse(1, 1);
    step(6);
    check("R2", "u0 count after fast falls", int'(cnt0), 20);
    check("R2", "u1 count after fast falls", int'(cnt1), 4);

    req_tag = "R9";
    run = 1'b1;
    repeat (5) pulse(2, 2);
    run = 1'b0;
    step(8);
    check("R8", "strobe idle", int'(stb0), 0);
    check("R10", "u1 data idle", int'(dat1), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule